// File: doc/BRIEF.md
# Three-Wire Potentiometer Step Sequencer

This block is the host side of a simple up/down control link to a digital potentiometer. The link has three lines: an active-low select, a direction level (high moves up), and an active-low step strobe. The potentiometer moves one tap on each falling edge of the strobe while it is selected. When select is released, the strobe level decides what happens next. If the strobe is high, the new position is written to non-volatile storage. If the strobe is low, the position is kept only until power is removed.

A client gives one command through a valid/ready port. The command holds a direction, a step count of 0 to 31 and a commit flag. The sequencer selects the part and presents the direction. It then emits the requested number of strobe pulses and releases select at the strobe level the commit flag asks for. It waits out the deselect hold time, which is long after a commit and short after a plain release, and then raises `done` for one cycle. Every interval is given in nanoseconds and turned into clock cycles by rounding up, with a minimum of one cycle.

Top module: `pot_step_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `pot_sel_n` and `pot_stb_n` are both high, `cmd_ready` is 1 and `done` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the block returns to idle after its `done` pulse.
- R3: `pot_sel_n` falls while `pot_stb_n` is high. `pot_up` takes the command's direction (1 = up, 0 = down) in the same cycle. The first falling strobe edge comes exactly C_CS + C_DIR cycles after `pot_sel_n` falls.
- R4: While selected, `pot_stb_n` has exactly as many falling edges as the command's step count.
- R5: Each strobe low phase that ends in a rising edge lasts at least C_LO cycles. Each high phase between two falling edges lasts at least C_HI cycles.
- R6: `pot_up` does not change while `pot_sel_n` is low.
- R7: With the commit flag set, `pot_stb_n` is high in the cycle before `pot_sel_n` rises and does not change in the cycle it rises.
- R8: With the commit flag clear and a non-zero count, the last strobe low phase is held through the release, so `pot_stb_n` is low when `pot_sel_n` rises and no extra falling edge occurs.
- R9: At least C_DESEL cycles pass between the last strobe transition (or the select fall, if the strobe never moved) and the rise of `pot_sel_n`.
- R10: `done` is raised exactly C_HOLD_ST cycles after `pot_sel_n` rises for a committing command, and exactly C_HOLD_NS cycles after it rises otherwise. Select stays high during that time.
- R11: `done` lasts one cycle, and `cmd_ready` is 1 in the cycle after it.
- R12: A zero-step committing command selects and releases with the strobe kept high. A zero-step non-committing command leaves both lines high and raises `done` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_up | input | 1 | Direction: 1 up, 0 down |
| cmd_steps | input | STEP_W | Number of strobe pulses |
| cmd_commit | input | 1 | 1: release with strobe high (store) |
| done | output | 1 | One-cycle end-of-command pulse |
| pot_sel_n | output | 1 | Active-low select line |
| pot_up | output | 1 | Direction line |
| pot_stb_n | output | 1 | Active-low step strobe |

## Verification
Assertions check several rules on every cycle. The lines are high whenever the block is ready. Select falls only with the strobe high, and the strobe falls only while selected. The direction holds steady while selected. The strobe level at release matches the latched commit flag. `done` is a single cycle, and neither counter moves past zero. Other behaviour only shows across whole commands, so the scoreboard scenarios cover it. These are the exact pulse counts, the setup and hold cycle counts, the minimum pulse widths and the gap before release. They also cover the extended final low phase of a non-committing release and the two zero-step cases.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_DIR, ST_LO, ST_HI, ST_DESEL, ST_HOLD, ST_DONE
  } seq_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/pot_seq_timer.sv
module pot_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9/R10 intervals rely on the count parking at zero
  a_r10_timer_parks: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/pot_seq_steps.sv
module pot_seq_steps #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero,
  output logic         last
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - 1'b1;
  end

  assign zero = (left == '0);
  assign last = (left == W'(1));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
endmodule

// File: rtl/pot_seq_ctrl.sv
module pot_seq_ctrl
  import pot_seq_pkg::*;
#(
  parameter int STEP_W  = 5,
  parameter int TW      = 8,
  parameter int C_CS    = 1,
  parameter int C_DIR   = 1,
  parameter int C_LO    = 1,
  parameter int C_HI    = 1,
  parameter int C_DESEL = 1,
  parameter int C_HS    = 1,
  parameter int C_HN    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_commit,
  input  logic              tmr_expired,
  input  logic              steps_zero,
  input  logic              steps_last,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              steps_load,
  output logic              steps_dec,
  output logic              cmd_ready,
  output logic              done,
  output logic              pot_sel_n,
  output logic              pot_up,
  output logic              pot_stb_n
);
  seq_state_t state, state_d;
  logic commit_q, commit_d, up_d;
  logic take;

  assign take = cmd_valid && cmd_ready;

  always_comb begin
    state_d    = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    steps_load = 1'b0;
    steps_dec  = 1'b0;
    commit_d   = commit_q;
    up_d       = pot_up;
    unique case (state)
      ST_IDLE: if (take) begin
        commit_d   = cmd_commit;
        up_d       = cmd_up;
        steps_load = 1'b1;
        if (cmd_steps == '0 && !cmd_commit) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_SEL;
          tmr_load = 1'b1;
          tmr_val  = TW'(C_CS - 1);
        end
      end
      ST_SEL: if (tmr_expired) begin
        state_d  = ST_DIR;
        tmr_load = 1'b1;
        tmr_val  = TW'(C_DIR - 1);
      end
      ST_DIR: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (steps_zero) begin
          state_d = ST_DESEL;
          tmr_val = TW'(C_DESEL - 1);
        end else begin
          state_d = ST_LO;
          tmr_val = TW'(C_LO - 1);
        end
      end
      ST_LO: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (steps_last && !commit_q) begin
          state_d = ST_DESEL;
          tmr_val = TW'(C_DESEL - 1);
        end else begin
          state_d = ST_HI;
          tmr_val = TW'(C_HI - 1);
        end
      end
      ST_HI: if (tmr_expired) begin
        tmr_load  = 1'b1;
        steps_dec = 1'b1;
        if (steps_last) begin
          state_d = ST_DESEL;
          tmr_val = TW'(C_DESEL - 1);
        end else begin
          state_d = ST_LO;
          tmr_val = TW'(C_LO - 1);
        end
      end
      ST_DESEL: if (tmr_expired) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = commit_q ? TW'(C_HS - 1) : TW'(C_HN - 1);
      end
      ST_HOLD: if (tmr_expired) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      commit_q  <= 1'b0;
      cmd_ready <= 1'b1;
      done      <= 1'b0;
      pot_sel_n <= 1'b1;
      pot_up    <= 1'b0;
      pot_stb_n <= 1'b1;
    end else begin
      state     <= state_d;
      commit_q  <= commit_d;
      pot_up    <= up_d;
      cmd_ready <= (state_d == ST_IDLE);
      done      <= (state_d == ST_DONE);
      pot_sel_n <= (state_d == ST_IDLE) || (state_d == ST_HOLD) || (state_d == ST_DONE);
      unique case (state_d)
        ST_LO:             pot_stb_n <= 1'b0;
        ST_DESEL, ST_HOLD: pot_stb_n <= commit_d;
        default:           pot_stb_n <= 1'b1;
      endcase
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (pot_sel_n && pot_stb_n && !done));
  a_r3_select_strobe_high: assert property (@(posedge clk) disable iff (rst)
    $fell(pot_sel_n) |-> pot_stb_n);
  a_r8_fall_only_selected: assert property (@(posedge clk) disable iff (rst)
    $fell(pot_stb_n) |-> !pot_sel_n);
  a_r6_dir_steady: assert property (@(posedge clk) disable iff (rst)
    (!pot_sel_n && $past(!pot_sel_n)) |-> $stable(pot_up));
  a_r7_release_level: assert property (@(posedge clk) disable iff (rst)
    $rose(pot_sel_n) |-> (pot_stb_n == commit_q));
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && cmd_ready));
endmodule

// File: rtl/pot_step_seq.sv
module pot_step_seq
  import pot_seq_pkg::*;
#(
  parameter int unsigned STEP_W       = 5,
  parameter int unsigned CLK_NS       = 8,
  parameter int unsigned T_CS_NS      = 100,
  parameter int unsigned T_DIR_NS     = 2900,
  parameter int unsigned T_LO_NS      = 1000,
  parameter int unsigned T_HI_NS      = 1000,
  parameter int unsigned T_DESEL_NS   = 1000,
  parameter int unsigned T_HOLD_ST_NS = 20_000_000,
  parameter int unsigned T_HOLD_NS_NS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_commit,
  output logic              done,
  output logic              pot_sel_n,
  output logic              pot_up,
  output logic              pot_stb_n
);
  localparam int unsigned C_CS    = ns_to_cyc(T_CS_NS, CLK_NS);
  localparam int unsigned C_DIR   = ns_to_cyc(T_DIR_NS, CLK_NS);
  localparam int unsigned C_LO    = ns_to_cyc(T_LO_NS, CLK_NS);
  localparam int unsigned C_HI    = ns_to_cyc(T_HI_NS, CLK_NS);
  localparam int unsigned C_DESEL = ns_to_cyc(T_DESEL_NS, CLK_NS);
  localparam int unsigned C_HS    = ns_to_cyc(T_HOLD_ST_NS, CLK_NS);
  localparam int unsigned C_HN    = ns_to_cyc(T_HOLD_NS_NS, CLK_NS);
  localparam int unsigned C_MAX01 = (C_CS > C_DIR) ? C_CS : C_DIR;
  localparam int unsigned C_MAX23 = (C_LO > C_HI) ? C_LO : C_HI;
  localparam int unsigned C_MAX45 = (C_DESEL > C_HN) ? C_DESEL : C_HN;
  localparam int unsigned C_MAXA  = (C_MAX01 > C_MAX23) ? C_MAX01 : C_MAX23;
  localparam int unsigned C_MAXB  = (C_MAX45 > C_HS) ? C_MAX45 : C_HS;
  localparam int unsigned C_MAX   = (C_MAXA > C_MAXB) ? C_MAXA : C_MAXB;
  localparam int          TW      = $clog2(C_MAX + 1);

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          steps_load, steps_dec, steps_zero, steps_last;

  pot_seq_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  pot_seq_steps #(.W(STEP_W)) steps_i (
    .clk(clk), .rst(rst), .load(steps_load), .load_val(cmd_steps), .dec(steps_dec),
    .zero(steps_zero), .last(steps_last)
  );

  pot_seq_ctrl #(
    .STEP_W(STEP_W), .TW(TW),
    .C_CS(int'(C_CS)), .C_DIR(int'(C_DIR)), .C_LO(int'(C_LO)), .C_HI(int'(C_HI)),
    .C_DESEL(int'(C_DESEL)), .C_HS(int'(C_HS)), .C_HN(int'(C_HN))
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_steps(cmd_steps), .cmd_commit(cmd_commit),
    .tmr_expired(tmr_expired), .steps_zero(steps_zero), .steps_last(steps_last),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .steps_load(steps_load), .steps_dec(steps_dec),
    .cmd_ready(cmd_ready), .done(done),
    .pot_sel_n(pot_sel_n), .pot_up(pot_up), .pot_stb_n(pot_stb_n)
  );
endmodule

// File: tb/pot_step_seq_tb_top.sv
module pot_step_seq_tb_top;
  // bench timing: 8 ns clock, every interval a whole number of cycles
  localparam int CS = 3, DIR = 5, LO = 4, HI = 5, DES = 3, HST = 40, HNS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, cmd_commit = 1'b0;
  logic [4:0] cmd_steps = '0;
  logic cmd_ready, done, pot_sel_n, pot_up, pot_stb_n;

  always #4 clk = ~clk;

  pot_step_seq #(
    .STEP_W(5), .CLK_NS(8), .T_CS_NS(24), .T_DIR_NS(40), .T_LO_NS(32), .T_HI_NS(40),
    .T_DESEL_NS(24), .T_HOLD_ST_NS(320), .T_HOLD_NS_NS(16)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_up(cmd_up),
    .cmd_steps(cmd_steps), .cmd_commit(cmd_commit), .done(done),
    .pot_sel_n(pot_sel_n), .pot_up(pot_up), .pot_stb_n(pot_stb_n)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { bit up; int steps; bit commit; } exp_t;
  exp_t exp_q[$];

  // monitor state
  bit prev_sel = 1, prev_stb = 1, sel_seen = 0, in_hold = 0;
  bit dir0, dir_bad, lo_bad, hi_bad, rel_lvl, rel_moved;
  int cyc, falls, first_fall, last_chg, gap, hold_cyc;

  always @(negedge clk) begin
    if (rst) begin
      prev_sel = 1; prev_stb = 1; sel_seen = 0; in_hold = 0;
    end else begin
      if (prev_sel && !pot_sel_n) begin
        sel_seen = 1; cyc = 0; falls = 0; first_fall = -1; last_chg = 0;
        dir0 = pot_up; dir_bad = 0; lo_bad = 0; hi_bad = 0;
        chk(pot_stb_n == 1'b1, "R3 strobe high at select", pot_stb_n, 1);
      end else if (!prev_sel && !pot_sel_n) begin
        cyc++;
        if (pot_up != dir0) dir_bad = 1;
        if (pot_stb_n != prev_stb) begin
          if (prev_stb) begin
            if (falls > 0 && cyc - last_chg < HI) hi_bad = 1;
            if (first_fall < 0) first_fall = cyc;
            falls++;
          end else if (cyc - last_chg < LO) lo_bad = 1;
          last_chg = cyc;
        end
      end else if (!prev_sel && pot_sel_n) begin
        rel_lvl = prev_stb; rel_moved = (pot_stb_n != prev_stb);
        gap = cyc + 1 - last_chg; in_hold = 1; hold_cyc = 0;
      end else if (in_hold) begin
        hold_cyc++;
      end

      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R11 done without command", 0, 1);
        end else begin
          e = exp_q.pop_front();
          if (e.steps == 0 && !e.commit) begin
            chk(!sel_seen, "R12 zero-step plain command touches lines", sel_seen, 0);
          end else begin
            chk(sel_seen, "R3 select seen", sel_seen, 1);
            chk(dir0 == e.up, "R3 direction", dir0, e.up);
            chk(falls == e.steps, "R4 falling strobe count", falls, e.steps);
            if (e.steps > 0)
              chk(first_fall == CS + DIR, "R3 select-to-first-strobe cycles", first_fall, CS + DIR);
            chk(!lo_bad, "R5 low phase width", lo_bad, 0);
            chk(!hi_bad, "R5 high phase width", hi_bad, 0);
            chk(!dir_bad, "R6 direction changed while selected", dir_bad, 0);
            if (e.commit) chk(rel_lvl && !rel_moved, "R7 strobe high at release", rel_lvl, 1);
            else          chk(!rel_lvl && !rel_moved, "R8 strobe low at release", rel_lvl, 0);
            chk(gap >= DES, "R9 gap before release", gap, DES);
            chk(hold_cyc == (e.commit ? HST : HNS), "R10 hold cycles", hold_cyc,
                e.commit ? HST : HNS);
          end
        end
        sel_seen = 0; in_hold = 0;
      end
      prev_sel = pot_sel_n; prev_stb = pot_stb_n;
    end
  end

  task automatic send(input bit up, input int steps, input bit commit);
    exp_t e;
    e.up = up; e.steps = steps; e.commit = commit;
    exp_q.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_up = up; cmd_steps = 5'(steps); cmd_commit = commit;
    @(negedge clk);
    cmd_valid = 0; cmd_up = ~up; cmd_steps = 5'd17; cmd_commit = ~commit;
    chk(cmd_ready == 1'b0, "R2 ready low after accept", cmd_ready, 0);
    if (steps == 0 && !commit)
      chk(done == 1'b1, "R12 zero-step plain done next cycle", done, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R11 ready after single done", cmd_ready, 1);
    chk(pot_sel_n && pot_stb_n, "R1 idle lines high", {pot_sel_n, pot_stb_n}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pot_sel_n && pot_stb_n && cmd_ready && !done, "R1 reset levels",
        {pot_sel_n, pot_stb_n, cmd_ready, done}, 4'b1110);
    rst = 0;
    @(negedge clk);
    chk(pot_sel_n && pot_stb_n && cmd_ready && !done, "R1 idle after reset",
        {pot_sel_n, pot_stb_n, cmd_ready, done}, 4'b1110);
    send(1, 5, 1);
    send(0, 3, 0);
    send(1, 0, 1);   // R12 store-only
    send(0, 0, 0);   // R12 no-op
    send(1, 1, 0);
    send(1, 1, 1);
    send(0, 31, 1);
    send(1, 2, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 every command completed", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule